// File: doc/BRIEF.md
# Two-Phase Indirect Register Port

This block is a low pin-count control port that a microprocessor uses to set up and query a larger device. The bus is byte wide. It has an active-low enable, a single select line and an active-low strobe. Every byte that moves in either direction takes two bus transfers. The first transfer is always a write with the select line low, and its byte is taken as an instruction that names an internal register and the direction of the next transfer. The second transfer, with the select line high, writes a byte into that register or reads a byte out of it.

The control lines and the inbound data are asynchronous to the system clock, so the block samples them through a flop synchronizer. A transfer completes on the rising edge of the strobe, and only while the enable is active. Inside the block there are a few writable setup registers, which drive the `cfg_o` bus, and a few read-only status bytes taken from `stat_i`. On a read the block drives the bus through a separate output and output-enable pair, and the pad ring forms the tristate driver from that pair. The drive may continue after the strobe ends. It stops when the enable goes inactive, or when the host starts a new instruction transfer.

Top module: `ctlport_top`

## Requirements
- R1: After reset all setup registers read zero on `cfg_o`, `bus_d_oe` is low and the port is waiting for an instruction.
- R2: A completed transfer with select low latches the byte as the instruction. Bit 7 set means the next data transfer is a read and bit 7 clear means it is a write. Bits 3:0 give the register index, and bits 6:4 are ignored.
- R3: A completed transfer with select high that follows a write instruction stores the bus byte into setup register 0 to 3 named by the index, and the new value appears on `cfg_o` (register n occupies bits 8n+7:8n).
- R4: During a data transfer that follows a read instruction, once the strobe goes low the port raises `bus_d_oe` and presents the register's value on `bus_d_o`. Index 8 returns `stat_i[7:0]` and index 9 returns `stat_i[15:8]`.
- R5: A strobe given while the enable is inactive has no effect: it neither latches an instruction nor writes a register.
- R6: A data transfer that arrives while no instruction is pending is ignored.
- R7: A second instruction transfer replaces a pending instruction that has not been used.
- R8: An index outside the setup and status ranges reads back as zero, and writes to it, or to a status index, change nothing.
- R9: Once a data transfer completes, the port waits for a new instruction, so a second data transfer right after it is ignored.
- R10: After a read strobe ends, `bus_d_oe` stays high while the enable stays active. It drops once the enable goes inactive, and it also drops when an instruction strobe (select low) begins.
- R11: A read that follows a drive left on until the enable went inactive returns the correct, newly selected value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en_n | input | 1 | Active-low port enable (asynchronous) |
| bus_sel | input | 1 | Phase select: low for instruction, high for data (asynchronous) |
| bus_stb_n | input | 1 | Active-low transfer strobe; a transfer completes on its rising edge |
| bus_d_i | input | 8 | Byte from the bus |
| bus_d_o | output | 8 | Byte driven onto the bus during reads |
| bus_d_oe | output | 1 | Output enable for the bus driver |
| stat_i | input | 16 | Read-only status bytes (index 8 in low byte, index 9 in high byte) |
| cfg_o | output | 32 | Setup register contents, register n at bits 8n+7:8n |

## Verification
The hardest situation to reach is a read whose bus drive was left on after the strobe, because the host held the enable active, and which is then followed by further traffic. Both ways of ending that drive have to be shown: the enable going inactive, and a fresh instruction strobe while the enable is still active. The stimulus therefore keeps the enable low across a complete read and checks `bus_d_oe` after the strobe has risen. It then either raises the enable or starts an instruction strobe, and it finishes with a new read of a different register to confirm the value is fresh.

// File: rtl/ctlport_pkg.sv
// Package: shared types for the two-phase indirect register port.
// Assumes: nothing beyond standard SystemVerilog.
package ctlport_pkg;

    // Phase of the transfer protocol: waiting for an instruction or for data.
    typedef enum logic {
        PH_WAIT_INSTR = 1'b0,
        PH_WAIT_DATA  = 1'b1
    } phase_t;

endpackage

// File: rtl/ctlport_sync.sv
// Module: multi-flop synchronizer for a bundle of asynchronous bus lines.
// Assumes: each line is held stable long enough (several clocks) that
// per-bit skew across the bundle does not matter to the consumer.
module ctlport_sync #(
    parameter int unsigned W       = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];

    // Shift the sampled lines through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ctlport_seq.sv
// Module: transfer sequencer. Finds the strobe edges and tracks the pending
// instruction. It issues a write pulse or a read-capture pulse for the
// data phase.
// Assumes: all inputs are already synchronized to clk. Instruction bit DW-1
// flags a read, and bits IDX_W-1:0 hold the register index.
module ctlport_seq
    import ctlport_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_act,
    input  logic             sel,
    input  logic             stb_low,
    input  logic [DW-1:0]    din,
    output logic             wr_pulse,
    output logic [IDX_W-1:0] reg_idx,
    output logic             rd_cap
);

    phase_t          phase_q;
    logic [DW-1:0]   instr_q;
    logic            stb_prev_q;
    logic            stb_rise;
    logic            stb_fall;
    logic            in_data;

    assign stb_rise = stb_prev_q && !stb_low;
    assign stb_fall = !stb_prev_q && stb_low;
    assign in_data  = (phase_q == PH_WAIT_DATA);

    // Track the strobe level and advance the protocol on each completed transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_WAIT_INSTR;
            instr_q    <= '0;
            stb_prev_q <= 1'b0;
        end else begin
            stb_prev_q <= stb_low;
            if (stb_rise && en_act) begin
                if (!sel) begin
                    instr_q <= din;
                    phase_q <= PH_WAIT_DATA;
                end else if (in_data) begin
                    phase_q <= PH_WAIT_INSTR;
                end
            end
        end
    end

    // Decode the data-phase actions from the pending instruction.
    always_comb begin
        reg_idx  = instr_q[IDX_W-1:0];
        wr_pulse = stb_rise && en_act && sel && in_data && !instr_q[DW-1];
        rd_cap   = stb_fall && en_act && sel && in_data &&  instr_q[DW-1];
    end

    // R2 / R7: an instruction transfer latches the byte and arms the data phase.
    assert_instr_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_rise && en_act && !sel) |=> (phase_q == PH_WAIT_DATA && instr_q == $past(din)));

    // R9: after any completed data-phase transfer the port waits for an instruction.
    assert_idle_after_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_rise && en_act && sel) |=> (phase_q == PH_WAIT_INSTR));

    // R5: nothing in the protocol state moves while the enable is inactive.
    assert_ignored_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_act |=> ($stable(instr_q) && $stable(phase_q)));

endmodule

// File: rtl/ctlport_regs.sv
// Module: register file. Holds NUM_SETUP writable bytes and a read mux over
// those bytes and NUM_STAT status bytes, the status bytes placed at STAT_BASE.
// Assumes: STAT_BASE+NUM_STAT fits in IDX_W bits and does not overlap the
// setup range. Any other index reads zero.
module ctlport_regs #(
    parameter int unsigned DW        = 8,
    parameter int unsigned IDX_W     = 4,
    parameter int unsigned NUM_SETUP = 4,
    parameter int unsigned NUM_STAT  = 2,
    parameter int unsigned STAT_BASE = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          idx,
    input  logic [DW-1:0]             wr_data,
    input  logic [NUM_STAT*DW-1:0]    stat_i,
    output logic [NUM_SETUP*DW-1:0]   cfg_o,
    output logic [DW-1:0]             rd_data
);

    logic [DW-1:0] setup_q [NUM_SETUP];
    logic          idx_known;

    for (genvar g = 0; g < NUM_SETUP; g++) begin : g_setup
        // Store a byte when the write pulse names this register.
        always_ff @(posedge clk) begin
            if (!rst_n)                               setup_q[g] <= '0;
            else if (wr_en && idx == IDX_W'(g))       setup_q[g] <= wr_data;
        end

        assign cfg_o[g*DW +: DW] = setup_q[g];

        // R3: a setup byte changes only in the cycle after a write pulse aimed at it.
        assert_write_only_by_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(setup_q[g]) |-> ($past(wr_en) && $past(idx) == IDX_W'(g)));
    end

    // Select the read value by index; undefined indices yield zero.
    always_comb begin
        rd_data   = '0;
        idx_known = 1'b0;
        for (int i = 0; i < NUM_SETUP; i++) begin
            if (idx == IDX_W'(i)) begin
                rd_data   = setup_q[i];
                idx_known = 1'b1;
            end
        end
        for (int i = 0; i < NUM_STAT; i++) begin
            if (idx == IDX_W'(STAT_BASE + i)) begin
                rd_data   = stat_i[i*DW +: DW];
                idx_known = 1'b1;
            end
        end
    end

    // R8: an index outside both ranges must read as zero.
    always_comb begin
        if (rst_n && !idx_known) begin
            assert_undef_reads_zero_R8: assert (rd_data == '0);
        end
    end

endmodule

// File: rtl/ctlport_top.sv
// Module: two-phase indirect register port top. Synchronizes the bus lines,
// sequences instruction/data transfers and owns the bus output driver.
// Assumes: the pad ring builds the tristate buffer from bus_d_o/bus_d_oe, and
// the host keeps each bus level stable for several system clocks.
module ctlport_top #(
    parameter int unsigned DW          = 8,
    parameter int unsigned IDX_W       = 4,
    parameter int unsigned NUM_SETUP   = 4,
    parameter int unsigned NUM_STAT    = 2,
    parameter int unsigned STAT_BASE   = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_en_n,
    input  logic                    bus_sel,
    input  logic                    bus_stb_n,
    input  logic [DW-1:0]           bus_d_i,
    output logic [DW-1:0]           bus_d_o,
    output logic                    bus_d_oe,
    input  logic [NUM_STAT*DW-1:0]  stat_i,
    output logic [NUM_SETUP*DW-1:0] cfg_o
);

    localparam int unsigned SW = DW + 3;

    logic [SW-1:0]    sync_s;
    logic             en_act;
    logic             sel_s;
    logic             stb_low;
    logic [DW-1:0]    din_s;
    logic             wr_pulse;
    logic             rd_cap;
    logic [IDX_W-1:0] reg_idx;
    logic [DW-1:0]    rd_data;
    logic             oe_q;
    logic [DW-1:0]    dout_q;

    ctlport_sync #(
        .W       (SW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({1'b1, 1'b0, 1'b1, {DW{1'b0}}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bus_en_n, bus_sel, bus_stb_n, bus_d_i}),
        .sync_o  (sync_s)
    );

    assign en_act  = !sync_s[SW-1];
    assign sel_s   =  sync_s[SW-2];
    assign stb_low = !sync_s[SW-3];
    assign din_s   =  sync_s[DW-1:0];

    ctlport_seq #(
        .DW    (DW),
        .IDX_W (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_act   (en_act),
        .sel      (sel_s),
        .stb_low  (stb_low),
        .din      (din_s),
        .wr_pulse (wr_pulse),
        .reg_idx  (reg_idx),
        .rd_cap   (rd_cap)
    );

    ctlport_regs #(
        .DW        (DW),
        .IDX_W     (IDX_W),
        .NUM_SETUP (NUM_SETUP),
        .NUM_STAT  (NUM_STAT),
        .STAT_BASE (STAT_BASE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_pulse),
        .idx     (reg_idx),
        .wr_data (din_s),
        .stat_i  (stat_i),
        .cfg_o   (cfg_o),
        .rd_data (rd_data)
    );

    // Own the bus drive: capture on a read strobe, release on disable or instruction strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            dout_q <= '0;
        end else if (!en_act) begin
            oe_q   <= 1'b0;
        end else if (stb_low && !sel_s) begin
            oe_q   <= 1'b0;
        end else if (rd_cap) begin
            oe_q   <= 1'b1;
            dout_q <= rd_data;
        end
    end

    assign bus_d_oe = oe_q;
    assign bus_d_o  = dout_q;

    // R10: an inactive enable always turns the driver off by the next clock.
    assert_oe_off_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_act |=> !bus_d_oe);

    // R4: the driver only switches on in response to a read capture.
    assert_oe_rise_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_d_oe) |-> $past(rd_cap));

endmodule

// File: tb/ctlport_top_bench.sv
`timescale 1ns/1ps
module ctlport_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en_n = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_stb_n = 1'b1;
    logic [7:0]  bus_d_i = 8'h00;
    logic [7:0]  bus_d_o;
    logic        bus_d_oe;
    logic [15:0] stat_i = 16'h3C96;
    logic [31:0] cfg_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ctlport_top u_ctlport_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en_n  (bus_en_n),
        .bus_sel   (bus_sel),
        .bus_stb_n (bus_stb_n),
        .bus_d_i   (bus_d_i),
        .bus_d_o   (bus_d_o),
        .bus_d_oe  (bus_d_oe),
        .stat_i    (stat_i),
        .cfg_o     (cfg_o)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] cfg(input int n);
        return cfg_o[n*8 +: 8];
    endfunction

    // One full strobe with the given select level and bus byte.
    task automatic xfer(input logic sel, input logic [7:0] d);
        bus_sel = sel;
        bus_d_i = d;
        idle(3);
        bus_stb_n = 1'b0;
        idle(6);
        bus_stb_n = 1'b1;
        idle(6);
    endtask

    // Read data phase: checks drive during the strobe and the hold after it.
    task automatic read_phase(input string tag, input logic [7:0] exp);
        bus_sel = 1'b1;
        idle(3);
        bus_stb_n = 1'b0;
        idle(6);
        check_eq({tag, " oe during strobe"}, {7'd0, bus_d_oe}, 8'd1);
        check_eq({tag, " data"}, bus_d_o, exp);
        bus_stb_n = 1'b1;
        idle(6);
        check_eq({tag, " R10 oe held after strobe"}, {7'd0, bus_d_oe}, 8'd1);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) check_eq("R1 setup reg zero", cfg(i), 8'h00);
        check_eq("R1 oe low", {7'd0, bus_d_oe}, 8'd0);
    endtask

    task automatic t_write();
        bus_en_n = 1'b0;
        xfer(1'b0, 8'h01);
        xfer(1'b1, 8'hA5);
        xfer(1'b0, 8'h73);          // R2: bits 6:4 ignored, index 3
        xfer(1'b1, 8'h5A);
        check_eq("R3 reg1 written", cfg(1), 8'hA5);
        check_eq("R2 reg3 via upper-bit instruction", cfg(3), 8'h5A);
        check_eq("R3 reg0 untouched", cfg(0), 8'h00);
    endtask

    task automatic t_read();
        xfer(1'b0, 8'h81);
        read_phase("R4 read reg1", 8'hA5);
        bus_en_n = 1'b1;
        idle(6);
        check_eq("R10 oe off after disable", {7'd0, bus_d_oe}, 8'd0);
        bus_en_n = 1'b0;
        xfer(1'b0, 8'h88);
        read_phase("R4 status idx8", 8'h96);
        xfer(1'b0, 8'h89);
        read_phase("R4 status idx9", 8'h3C);
        bus_en_n = 1'b1;
        idle(6);
    endtask

    task automatic t_instr_drop();
        bus_en_n = 1'b0;
        xfer(1'b0, 8'h83);
        read_phase("R4 read reg3", 8'h5A);
        bus_sel = 1'b0;
        bus_d_i = 8'h8F;
        idle(3);
        bus_stb_n = 1'b0;
        idle(6);
        check_eq("R10 oe off on instruction strobe", {7'd0, bus_d_oe}, 8'd0);
        bus_stb_n = 1'b1;
        idle(6);
        read_phase("R8 undefined idx15 reads zero", 8'h00);
        bus_en_n = 1'b1;
        idle(6);
    endtask

    task automatic t_disabled();
        bus_en_n = 1'b1;
        xfer(1'b0, 8'h02);
        bus_en_n = 1'b0;
        xfer(1'b1, 8'h33);
        check_eq("R5 strobe while disabled ignored", cfg(2), 8'h00);
    endtask

    task automatic t_orphan();
        xfer(1'b1, 8'h44);
        check_eq("R6 orphan data reg0", cfg(0), 8'h00);
        check_eq("R6 orphan data reg2", cfg(2), 8'h00);
    endtask

    task automatic t_replace();
        xfer(1'b0, 8'h00);
        xfer(1'b0, 8'h02);
        xfer(1'b1, 8'h5C);
        check_eq("R7 replaced target written", cfg(2), 8'h5C);
        check_eq("R7 first target untouched", cfg(0), 8'h00);
    endtask

    task automatic t_undef();
        xfer(1'b0, 8'h05);
        xfer(1'b1, 8'h77);
        xfer(1'b0, 8'h08);
        xfer(1'b1, 8'h77);
        for (int i = 0; i < 4; i++)
            check_eq("R8 no setup change", cfg(i), (i == 1) ? 8'hA5 : (i == 2) ? 8'h5C : (i == 3) ? 8'h5A : 8'h00);
        xfer(1'b0, 8'h85);
        read_phase("R8 idx5 reads zero", 8'h00);
        xfer(1'b0, 8'h88);
        read_phase("R8 status unchanged by write", 8'h96);
    endtask

    task automatic t_return();
        xfer(1'b0, 8'h01);
        xfer(1'b1, 8'h11);
        xfer(1'b1, 8'h22);
        check_eq("R9 second data phase ignored", cfg(1), 8'h11);
    endtask

    task automatic t_held_read();
        xfer(1'b0, 8'h82);
        read_phase("R11 first read", 8'h5C);
        bus_en_n = 1'b1;
        idle(6);
        check_eq("R11 drive released", {7'd0, bus_d_oe}, 8'd0);
        bus_en_n = 1'b0;
        xfer(1'b0, 8'h83);
        read_phase("R11 later read correct", 8'h5A);
        bus_en_n = 1'b1;
        idle(6);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(4);
        t_reset();
        t_write();
        t_read();
        t_instr_drop();
        t_disabled();
        t_orphan();
        t_replace();
        t_undef();
        t_return();
        t_held_read();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule